// File: doc/BRIEF.md
# Parallel-Word Run-Length Loss Detector

This block watches the stream of 10-bit parallel words coming out of a receive deserializer and raises a loss-of-signal flag when the line has been stuck at one level for too long. Each accepted word (qualified by a valid strobe) is classed as all-ones, all-zeros or mixed. The block counts consecutive words of the same constant class. When that count reaches 12, the flag is raised so that the lock decision logic can drop lock on the incoming data quickly.

The block counts whole constant words, not single bits. The bit-run length that trips it therefore depends on where the run falls relative to word boundaries. A run of 119 identical bits can never fill 12 whole words, so it never trips the flag. A run of 129 identical bits always fills at least 12 whole words, so it always trips the flag. Runs between those two lengths trip the flag or not, depending on alignment. A companion run-length-ok output is the complement of the flag, for logic that wants a qualifying level.

Top module: `rll_loss_detect`

## Requirements
- R1: After 12 consecutive valid all-ones words (word_i == 10'h3FF), los_o is 1 from the rising clock edge that accepts the 12th word.
- R2: After 12 consecutive valid all-zeros words (word_i == 10'h000), los_o is 1 from the rising clock edge that accepts the 12th word.
- R3: A run of 11 or fewer constant words leaves los_o at 0. A valid mixed word (neither 10'h3FF nor 10'h000) restarts the count at zero.
- R4: A valid constant word of the opposite value to the current run restarts the count at one for the new value. That word is the first of the new run.
- R5: While los_o is 1, the first valid word that is mixed, or that has the opposite constant value, clears los_o on the edge that accepts it.
- R6: Cycles with valid_i low are ignored. The count neither advances nor restarts, and los_o keeps its value, whatever word_i carries.
- R7: run_ok_o is always the complement of los_o.
- R8: A run of 119 identical bits never sets los_o, at any of the 10 alignments and for either bit value. Here serial bit n is carried in word n/10, bit position n%10.
- R9: A run of 129 identical bits always sets los_o, at every alignment and for either bit value, using the same packing as R8.
- R10: While rst_ni is low and after reset is released, los_o is 0 and run_ok_o is 1 until a qualifying run has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | 10 | Received parallel word |
| valid_i | input | 1 | word_i carries a word this cycle |
| los_o | output | 1 | Loss of signal: stuck run of 12 constant words |
| run_ok_o | output | 1 | Complement of los_o |

## Verification
The hardest case is a bit run whose length sits right at the threshold, placed at every offset against the word grid. Such a run produces one or two mixed edge words around a variable number of full constant words, and the mixed edge words are easy to miss with hand-made word patterns. The bench therefore builds each run as a serial bit stream: opposite-valued lead-in bits, the run itself, then opposite-valued tail bits. It packs that stream into words for lengths 119 and 129, for all ten offsets and both bit values. A behavioural history model then checks the flag on every cycle. Each segment is also checked for whether the flag was ever seen high.

// File: rtl/rll_pkg.sv
package rll_pkg;
  typedef enum logic [1:0] {
    CLS_MIXED = 2'd0,
    CLS_ZERO  = 2'd1,
    CLS_ONE   = 2'd2
  } word_class_e;
endpackage

// File: rtl/rll_word_classify.sv
module rll_word_classify
  import rll_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic [WORD_W-1:0] word_i,
  output word_class_e       cls_o
);
  logic all_one, all_zero;
  assign all_one  = &word_i;
  assign all_zero = ~|word_i;

  always_comb begin
    if (all_one)       cls_o = CLS_ONE;
    else if (all_zero) cls_o = CLS_ZERO;
    else               cls_o = CLS_MIXED;
  end
endmodule

// File: rtl/rll_run_counter.sv
module rll_run_counter
  import rll_pkg::*;
#(
  parameter int RUN_WORDS = 12,
  localparam int CNT_W = $clog2(RUN_WORDS + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  word_class_e cls_i,
  output logic        hit_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_WORDS);
  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  word_class_e      cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cls_q <= CLS_MIXED;
    end else if (valid_i) begin
      cls_q <= cls_i;
      if (cls_i == CLS_MIXED)   cnt_q <= '0;
      else if (cls_i != cls_q)  cnt_q <= RUN_ONE;   // new polarity starts at one
      else if (cnt_q != RUN_MAX) cnt_q <= cnt_q + RUN_ONE;  // saturate
    end
  end

  assign hit_o = (cnt_q == RUN_MAX);
endmodule

// File: rtl/rll_loss_detect.sv
module rll_loss_detect
  import rll_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              los_o,
  output logic              run_ok_o
);
  word_class_e cls;
  logic        hit;

  rll_word_classify #(.WORD_W(WORD_W)) u_classify (
    .word_i (word_i),
    .cls_o  (cls)
  );

  rll_run_counter #(.RUN_WORDS(RUN_WORDS)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .cls_i   (cls),
    .hit_o   (hit)
  );

  assign los_o    = hit;
  assign run_ok_o = ~hit;
endmodule

// File: rtl/rll_loss_detect_chk.sv
module rll_loss_detect_chk #(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12,
  localparam int CNT_W = $clog2(RUN_WORDS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              valid_i,
  input logic              los_o,
  input logic              run_ok_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_WORDS);
  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

  // independent tracker: repeats of an identical constant word
  logic [CNT_W-1:0]  chk_run_q;
  logic [WORD_W-1:0] last_q;
  logic              is_const;
  assign is_const = (&word_i) || (~|word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_run_q <= '0;
      last_q    <= '0;
    end else if (valid_i) begin
      last_q <= word_i;
      if (!is_const) chk_run_q <= '0;
      else if (chk_run_q == '0 || word_i != last_q) chk_run_q <= RUN_ONE;
      else if (chk_run_q != RUN_MAX) chk_run_q <= chk_run_q + RUN_ONE;
    end
  end

  // R1 / R3: flag only after a full run
  assert_min_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_o |-> (chk_run_q == RUN_MAX));

  // R2: full run always flags
  assert_full_run_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_run_q == RUN_MAX) |-> los_o);

  assert_mixed_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_const) |=> !los_o);

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(los_o));

  assert_ok_inverse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_ok_o == !los_o);

  always_comb begin
    if (!rst_ni) assert_reset_R10: assert (!los_o && run_ok_o);
  end
endmodule

bind rll_loss_detect rll_loss_detect_chk #(
  .WORD_W    (WORD_W),
  .RUN_WORDS (RUN_WORDS)
) u_chk (.*);

// File: tb/rll_loss_detect_tb.sv
`timescale 1ns/1ps
module rll_loss_detect_tb_top;
  localparam int WW = 10;
  localparam int RUN = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] word = '0;
  logic          valid = 1'b0;
  logic          los, run_ok;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    seen_los = 1'b0;
  string cur_req = "R10";
  int    hist[$];

  always #2 clk = ~clk;

  rll_loss_detect #(.WORD_W(WW), .RUN_WORDS(RUN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .valid_i(valid),
    .los_o(los), .run_ok_o(run_ok)
  );

  // behavioural model: history of last RUN word classes (0 mixed, 1 zero, 2 one)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist.delete();
    else if (valid) begin
      hist.push_back(word == '1 ? 2 : (word == '0 ? 1 : 0));
      if (hist.size() > RUN) void'(hist.pop_front());
    end
  end

  function automatic bit model_los();
    if (hist.size() < RUN) return 1'b0;
    if (hist[0] == 0) return 1'b0;
    foreach (hist[i]) if (hist[i] != hist[0]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (los === 1'b1) seen_los = 1'b1;
      check({cur_req, " model los_o"}, los, model_los());
      check("R7 run_ok_o", run_ok, ~model_los());
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic send(logic [WW-1:0] w);
    @(negedge clk);
    word  = w;
    valid = 1'b1;
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic send_n(logic [WW-1:0] w, int n);
    for (int i = 0; i < n; i++) send(w);
  endtask

  task automatic idle(int n, logic [WW-1:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word  = junk;
      valid = 1'b0;
    end
    @(posedge clk);
    #1;
  endtask

  // serial bit run of length len, value v, after off opposite bits
  task automatic bit_run(int len, int off, bit v);
    int total = off + len;
    int nw = (total + WW - 1) / WW;
    send(10'h155);
    @(negedge clk);
    seen_los = 1'b0;
    for (int k = 0; k < nw; k++) begin
      logic [WW-1:0] w;
      for (int b = 0; b < WW; b++) begin
        int n = k * WW + b;
        w[b] = (n >= off && n < total) ? v : ~v;
      end
      send(w);
    end
    send(10'h155);
  endtask

  initial begin
    cur_req = "R10";
    #1 check("R10 los_o in reset", los, 1'b0);
    check("R10 run_ok_o in reset", run_ok, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2, 10'h3FF);
    check("R10 los_o after reset", los, 1'b0);
    check("R10 run_ok_o after reset", run_ok, 1'b1);

    cur_req = "R1";
    send_n(10'h3FF, 11);
    check("R3 11 ones no flag", los, 1'b0);
    send(10'h3FF);
    check("R1 12th ones word flags", los, 1'b1);
    check("R7 run_ok_o low", run_ok, 1'b0);
    send_n(10'h3FF, 3);
    check("R1 flag holds on longer run", los, 1'b1);

    cur_req = "R5";
    send(10'h2A5);
    check("R5 mixed word clears", los, 1'b0);

    cur_req = "R2";
    send_n(10'h000, 11);
    check("R3 11 zeros no flag", los, 1'b0);
    send(10'h000);
    check("R2 12th zeros word flags", los, 1'b1);

    cur_req = "R5";
    send(10'h3FF);
    check("R5 opposite word clears", los, 1'b0);

    cur_req = "R4";
    send_n(10'h3FF, 10);
    send_n(10'h000, 11);
    check("R4 opposite restarts at one, 11 zeros", los, 1'b0);
    send(10'h000);
    check("R4 12th zeros after switch flags", los, 1'b1);

    cur_req = "R3";
    send(10'h001);
    send_n(10'h000, 6);
    send(10'h200);
    send_n(10'h000, 11);
    check("R3 mixed restarts count", los, 1'b0);
    send(10'h000);
    check("R3 full run after restart flags", los, 1'b1);
    send(10'h3FE);

    cur_req = "R6";
    send_n(10'h3FF, 6);
    idle(5, 10'h155);
    check("R6 idle mixed ignored, no flag", los, 1'b0);
    idle(3, 10'h000);
    send_n(10'h3FF, 6);
    check("R6 count held across idle", los, 1'b1);
    idle(4, 10'h0F0);
    check("R6 flag held while idle", los, 1'b1);
    send(10'h155);

    for (int v = 0; v < 2; v++) begin
      for (int off = 0; off < WW; off++) begin
        cur_req = "R8";
        bit_run(119, off, v[0]);
        check($sformatf("R8 119-bit run off=%0d v=%0d no flag", off, v), seen_los, 1'b0);
        cur_req = "R9";
        bit_run(129, off, v[0]);
        check($sformatf("R9 129-bit run off=%0d v=%0d flags", off, v), seen_los, 1'b1);
      end
    end

    idle(2, 10'h155);
    finish_run();
  end
endmodule